// File: doc/BRIEF.md
# Thread Register Window Address Translator

This block turns a 5-bit register specifier issued by a hardware thread into an index into a large shared physical register file. There is no renaming. Each thread slot holds a window base, recorded when the thread is launched. The physical index is a base plus an offset, and the class of the specifier picks both the base and the offset. Specifiers fall into four classes: global values read from the creating context, shared values passed from a thread to its successor, private local values, and a hard-wired zero register.

A launch port writes a slot's entry. The entry holds the thread's own base, the family's global base, the creating context's base, the predecessor slot and a first-of-family flag. A terminate port empties a slot. The lookup port is purely combinational. From a slot, a specifier and a write flag it returns a physical index, a class code, a permission flag and an error flag. A shared read takes the predecessor's window, or the creating context's window for the first thread of a family. A shared write goes to the thread's own window. A write to a global register or to the zero register is refused.

Top module: `regctx_xlate`

## Requirements
- R1: Specifiers 0 to 7 have class 1 (global), 8 to 11 have class 2 (shared), 12 to 30 have class 0 (local) and 31 has class 3 (zero), shown on `lk_class`.
- R2: A local access yields the slot's own base plus (specifier - 8), modulo 1024, and is allowed for both reads and writes.
- R3: A global access yields the slot's global base plus the specifier. Reads are allowed and writes are refused (`lk_allow` = 0).
- R4: A shared write yields the slot's own base plus (specifier - 8) and is allowed.
- R5: A shared read by a thread that is not first in its family yields the predecessor slot's base plus (specifier - 8).
- R6: A shared read by the first thread of a family yields the creating context's base plus (specifier - 8).
- R7: Specifier 31 gives index 0. A read of it is allowed and a write to it is refused.
- R8: A launch writes the slot entry at the clock edge, and lookups see it from the next cycle.
- R9: A terminate empties the slot. A lookup on an empty slot gives `lk_err` = 1, `lk_allow` = 0 and index 0.
- R10: A shared read by a non-first thread whose predecessor slot is empty gives `lk_err` = 1, `lk_allow` = 0 and index 0.
- R11: When a launch and a terminate name the same slot in the same cycle, the launch takes effect.
- R12: Reset empties every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| launch_valid | input | 1 | Load a slot entry |
| launch_slot | input | 3 | Slot being loaded |
| launch_base | input | 10 | Thread's own window base |
| launch_gbase | input | 10 | Family global base |
| launch_cbase | input | 10 | Creating context base, used for the first thread's shared reads |
| launch_pred | input | 3 | Predecessor slot |
| launch_first | input | 1 | Thread is first in its family |
| term_valid | input | 1 | Empty a slot |
| term_slot | input | 3 | Slot being emptied |
| lk_slot | input | 3 | Lookup slot |
| lk_spec | input | 5 | Architectural specifier |
| lk_write | input | 1 | Lookup is for a write |
| lk_index | output | 10 | Physical register index |
| lk_class | output | 2 | Class code (0 local, 1 global, 2 shared, 3 zero) |
| lk_allow | output | 1 | Access permitted |
| lk_err | output | 1 | Slot empty or predecessor missing |

## Verification
The assertions assume that slot numbers stay below the slot count and that the launch inputs are stable only when they are sampled at the clock edge. The launch-visibility property further assumes that no terminate hits the same slot in the cycle right after its launch. Directed stimulus uses only in-range slots. The randomized phase draws the terminate slot from slots other than the one launched in the previous cycle, and it also issues launch and terminate to the same slot in one cycle, which the properties allow.

// File: rtl/regctx_pkg.sv
package regctx_pkg;
  typedef enum logic [1:0] {
    CLS_LOCAL  = 2'd0,
    CLS_GLOBAL = 2'd1,
    CLS_SHARED = 2'd2,
    CLS_ZERO   = 2'd3
  } reg_class_e;
endpackage

// File: rtl/regctx_slot_table.sv
module regctx_slot_table #(
  parameter int NUM_SLOTS = 8,
  parameter int PHYS_W    = 10,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic [SLOT_W-1:0] launch_slot,
  input  logic [PHYS_W-1:0] launch_base,
  input  logic [PHYS_W-1:0] launch_gbase,
  input  logic [PHYS_W-1:0] launch_cbase,
  input  logic [SLOT_W-1:0] launch_pred,
  input  logic              launch_first,
  input  logic              term_valid,
  input  logic [SLOT_W-1:0] term_slot,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic              cur_valid,
  output logic [PHYS_W-1:0] cur_base,
  output logic [PHYS_W-1:0] cur_gbase,
  output logic [PHYS_W-1:0] cur_cbase,
  output logic              cur_first,
  output logic              pred_valid,
  output logic [PHYS_W-1:0] pred_base
);
  logic [NUM_SLOTS-1:0] valid_q, valid_d, load_en;
  logic [PHYS_W-1:0]    base_q  [NUM_SLOTS];
  logic [PHYS_W-1:0]    gbase_q [NUM_SLOTS];
  logic [PHYS_W-1:0]    cbase_q [NUM_SLOTS];
  logic [SLOT_W-1:0]    pred_q  [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] first_q;
  logic [SLOT_W-1:0]    pred_idx;

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic clr_en;
    assign load_en[s] = launch_valid && (launch_slot == SLOT_W'(s));
    assign clr_en     = term_valid && (term_slot == SLOT_W'(s));
    // launch wins over terminate on the same slot
    assign valid_d[s] = load_en[s] | (valid_q[s] & ~clr_en);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) valid_q[s] <= 1'b0;
      else        valid_q[s] <= valid_d[s];
    end

    always_ff @(posedge clk) begin
      if (load_en[s]) begin
        base_q[s]  <= launch_base;
        gbase_q[s] <= launch_gbase;
        cbase_q[s] <= launch_cbase;
        pred_q[s]  <= launch_pred;
        first_q[s] <= launch_first;
      end
    end
  end

  always_comb begin
    cur_valid  = valid_q[rd_slot];
    cur_base   = base_q[rd_slot];
    cur_gbase  = gbase_q[rd_slot];
    cur_cbase  = cbase_q[rd_slot];
    cur_first  = first_q[rd_slot];
    pred_idx   = pred_q[rd_slot];
    pred_valid = valid_q[pred_idx];
    pred_base  = base_q[pred_idx];
  end
endmodule

// File: rtl/regctx_classify.sv
module regctx_classify
  import regctx_pkg::*;
#(
  parameter int SPEC_W  = 5,
  parameter int GLB_CNT = 8,
  parameter int SHR_CNT = 4
) (
  input  logic [SPEC_W-1:0] spec,
  output reg_class_e        cls,
  output logic [SPEC_W-1:0] offset
);
  localparam logic [SPEC_W-1:0] GLB_LIM   = SPEC_W'(GLB_CNT);
  localparam logic [SPEC_W-1:0] SHR_LIM   = SPEC_W'(GLB_CNT + SHR_CNT);
  localparam logic [SPEC_W-1:0] ZERO_SPEC = '1;

  always_comb begin
    if (spec == ZERO_SPEC) begin
      cls    = CLS_ZERO;
      offset = '0;
    end else if (spec < GLB_LIM) begin
      cls    = CLS_GLOBAL;
      offset = spec;
    end else if (spec < SHR_LIM) begin
      cls    = CLS_SHARED;
      offset = spec - GLB_LIM;
    end else begin
      cls    = CLS_LOCAL;
      offset = spec - GLB_LIM;
    end
  end
endmodule

// File: rtl/regctx_addr_gen.sv
module regctx_addr_gen
  import regctx_pkg::*;
#(
  parameter int PHYS_W = 10,
  parameter int SPEC_W = 5
) (
  input  reg_class_e        cls,
  input  logic [SPEC_W-1:0] offset,
  input  logic              is_write,
  input  logic              cur_valid,
  input  logic [PHYS_W-1:0] cur_base,
  input  logic [PHYS_W-1:0] cur_gbase,
  input  logic [PHYS_W-1:0] cur_cbase,
  input  logic              cur_first,
  input  logic              pred_valid,
  input  logic [PHYS_W-1:0] pred_base,
  output logic [PHYS_W-1:0] index,
  output logic              allow,
  output logic              err
);
  localparam int PAD_W = PHYS_W - SPEC_W;

  logic [PHYS_W-1:0] sel_base;
  logic [PHYS_W-1:0] off_ext;
  logic              shr_read;

  assign off_ext  = {{PAD_W{1'b0}}, offset};
  assign shr_read = (cls == CLS_SHARED) && !is_write;

  always_comb begin
    unique case (cls)
      CLS_GLOBAL: sel_base = cur_gbase;
      CLS_SHARED: sel_base = !shr_read ? cur_base :
                             (cur_first ? cur_cbase : pred_base);
      CLS_LOCAL:  sel_base = cur_base;
      default:    sel_base = '0;
    endcase
  end

  always_comb begin
    err   = !cur_valid || (shr_read && !cur_first && !pred_valid);
    allow = !err && !(is_write && (cls == CLS_GLOBAL || cls == CLS_ZERO));
    index = (err || cls == CLS_ZERO) ? '0 : sel_base + off_ext;
  end
endmodule

// File: rtl/regctx_xlate.sv
module regctx_xlate
  import regctx_pkg::*;
#(
  parameter int NUM_SLOTS = 8,
  parameter int PHYS_W    = 10,
  parameter int SPEC_W    = 5,
  parameter int GLB_CNT   = 8,
  parameter int SHR_CNT   = 4,
  localparam int SLOT_W   = $clog2(NUM_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              launch_valid,
  input  logic [SLOT_W-1:0] launch_slot,
  input  logic [PHYS_W-1:0] launch_base,
  input  logic [PHYS_W-1:0] launch_gbase,
  input  logic [PHYS_W-1:0] launch_cbase,
  input  logic [SLOT_W-1:0] launch_pred,
  input  logic              launch_first,
  input  logic              term_valid,
  input  logic [SLOT_W-1:0] term_slot,
  input  logic [SLOT_W-1:0] lk_slot,
  input  logic [SPEC_W-1:0] lk_spec,
  input  logic              lk_write,
  output logic [PHYS_W-1:0] lk_index,
  output logic [1:0]        lk_class,
  output logic              lk_allow,
  output logic              lk_err
);
  logic              cur_valid, cur_first, pred_valid;
  logic [PHYS_W-1:0] cur_base, cur_gbase, cur_cbase, pred_base;
  reg_class_e        cls;
  logic [SPEC_W-1:0] offset;

  regctx_slot_table #(.NUM_SLOTS(NUM_SLOTS), .PHYS_W(PHYS_W)) u_table (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_slot(launch_slot),
    .launch_base(launch_base), .launch_gbase(launch_gbase),
    .launch_cbase(launch_cbase), .launch_pred(launch_pred),
    .launch_first(launch_first),
    .term_valid(term_valid), .term_slot(term_slot),
    .rd_slot(lk_slot),
    .cur_valid(cur_valid), .cur_base(cur_base), .cur_gbase(cur_gbase),
    .cur_cbase(cur_cbase), .cur_first(cur_first),
    .pred_valid(pred_valid), .pred_base(pred_base)
  );

  regctx_classify #(.SPEC_W(SPEC_W), .GLB_CNT(GLB_CNT), .SHR_CNT(SHR_CNT)) u_cls (
    .spec(lk_spec), .cls(cls), .offset(offset)
  );

  regctx_addr_gen #(.PHYS_W(PHYS_W), .SPEC_W(SPEC_W)) u_addr (
    .cls(cls), .offset(offset), .is_write(lk_write),
    .cur_valid(cur_valid), .cur_base(cur_base), .cur_gbase(cur_gbase),
    .cur_cbase(cur_cbase), .cur_first(cur_first),
    .pred_valid(pred_valid), .pred_base(pred_base),
    .index(lk_index), .allow(lk_allow), .err(lk_err)
  );

  assign lk_class = cls;
endmodule

// File: rtl/regctx_xlate_chk.sv
module regctx_xlate_chk
  import regctx_pkg::*;
#(
  parameter int PHYS_W  = 10,
  parameter int SPEC_W  = 5,
  parameter int SLOT_W  = 3,
  parameter int GLB_CNT = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              launch_valid,
  input logic [SLOT_W-1:0] launch_slot,
  input logic [PHYS_W-1:0] launch_base,
  input logic              term_valid,
  input logic [SLOT_W-1:0] term_slot,
  input logic [SLOT_W-1:0] lk_slot,
  input logic [SPEC_W-1:0] lk_spec,
  input logic              lk_write,
  input logic [PHYS_W-1:0] lk_index,
  input logic [1:0]        lk_class,
  input logic              lk_allow,
  input logic              lk_err
);
  localparam logic [SPEC_W-1:0] GLB_LIM = SPEC_W'(GLB_CNT);
  logic [PHYS_W-1:0] loc_off;
  assign loc_off = {{(PHYS_W-SPEC_W){1'b0}}, lk_spec - GLB_LIM};

  AST_GLOBAL_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_spec < GLB_LIM) |-> (lk_class == CLS_GLOBAL)); // R1
  AST_GLOBAL_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_class == CLS_GLOBAL && lk_write) |-> !lk_allow); // R3
  AST_ZERO_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_spec == '1 && lk_write) |-> (!lk_allow && lk_index == '0)); // R7
  AST_ERR_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    lk_err |-> (!lk_allow && lk_index == '0)); // R9
  AST_LAUNCH_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
    launch_valid |=> (lk_slot != $past(launch_slot) || lk_class != CLS_LOCAL ||
                      lk_index == $past(launch_base) + loc_off)); // R8
  AST_TERM_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (term_valid && !(launch_valid && launch_slot == term_slot))
      |=> (lk_slot != $past(term_slot) || lk_err)); // R9
endmodule

bind regctx_xlate regctx_xlate_chk #(
  .PHYS_W(PHYS_W), .SPEC_W(SPEC_W), .SLOT_W(SLOT_W), .GLB_CNT(GLB_CNT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .launch_valid(launch_valid),
  .launch_slot(launch_slot), .launch_base(launch_base),
  .term_valid(term_valid), .term_slot(term_slot),
  .lk_slot(lk_slot), .lk_spec(lk_spec), .lk_write(lk_write),
  .lk_index(lk_index), .lk_class(lk_class), .lk_allow(lk_allow), .lk_err(lk_err)
);

// File: tb/regctx_xlate_bench.sv
`timescale 1ns/1ps
module regctx_xlate_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       launch_valid, launch_first, term_valid, lk_write;
  logic [2:0] launch_slot, launch_pred, term_slot, lk_slot;
  logic [9:0] launch_base, launch_gbase, launch_cbase;
  logic [4:0] lk_spec;
  logic [9:0] lk_index;
  logic [1:0] lk_class;
  logic       lk_allow, lk_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  int m_valid [8];
  int m_base  [8];
  int m_gbase [8];
  int m_cbase [8];
  int m_pred  [8];
  int m_first [8];

  always #2.5 clk = ~clk;

  regctx_xlate u_regctx_xlate (
    .clk(clk), .rst_n(rst_n),
    .launch_valid(launch_valid), .launch_slot(launch_slot),
    .launch_base(launch_base), .launch_gbase(launch_gbase),
    .launch_cbase(launch_cbase), .launch_pred(launch_pred),
    .launch_first(launch_first),
    .term_valid(term_valid), .term_slot(term_slot),
    .lk_slot(lk_slot), .lk_spec(lk_spec), .lk_write(lk_write),
    .lk_index(lk_index), .lk_class(lk_class), .lk_allow(lk_allow), .lk_err(lk_err)
  );

  // compare outputs to the model, then apply this cycle's table updates to it
  task automatic cycle(input string note);
    int s, sp, cls, off, base, e_idx, e_err, e_allow, w;
    string req;
    #1;
    s  = int'(lk_slot);
    sp = int'(lk_spec);
    w  = int'(lk_write);
    if (sp == 31) cls = 3;
    else if (sp < 8) cls = 1;
    else if (sp < 12) cls = 2;
    else cls = 0;
    off = (cls == 1) ? sp : sp - 8;
    e_err = (!rst_n || m_valid[s] == 0) ? 1 : 0;
    if (!e_err && cls == 2 && !w && m_first[s] == 0 && m_valid[m_pred[s]] == 0) e_err = 1;
    base = 0;
    case (cls)
      0: base = m_base[s];
      1: base = m_gbase[s];
      2: base = w ? m_base[s] : (m_first[s] != 0 ? m_cbase[s] : m_base[m_pred[s]]);
      default: base = 0;
    endcase
    e_idx   = (e_err || cls == 3) ? 0 : (base + off) % 1024;
    e_allow = (!e_err && !(w && (cls == 1 || cls == 3))) ? 1 : 0;
    if (!rst_n) req = "R12";
    else if (e_err && m_valid[s] != 0) req = "R10";
    else if (e_err) req = "R9";
    else if (cls == 3) req = "R7";
    else if (cls == 1) req = "R3";
    else if (cls == 2 && w) req = "R4";
    else if (cls == 2 && m_first[s] != 0) req = "R6";
    else if (cls == 2) req = "R5";
    else req = "R2";
    total++;
    if (int'(lk_class) != cls) begin
      bad++;
      $display("FAIL R1 %s class got %0d exp %0d", note, lk_class, cls);
    end else if (int'(lk_index) != e_idx || int'(lk_err) != e_err || int'(lk_allow) != e_allow) begin
      bad++;
      $display("FAIL %s %s got idx=%0d err=%0d allow=%0d exp idx=%0d err=%0d allow=%0d",
               req, note, lk_index, lk_err, lk_allow, e_idx, e_err, e_allow);
    end
    if (rst_n) begin
      if (term_valid) m_valid[term_slot] = 0;
      if (launch_valid) begin
        m_valid[launch_slot] = 1;
        m_base[launch_slot]  = int'(launch_base);
        m_gbase[launch_slot] = int'(launch_gbase);
        m_cbase[launch_slot] = int'(launch_cbase);
        m_pred[launch_slot]  = int'(launch_pred);
        m_first[launch_slot] = int'(launch_first);
      end
    end
    @(negedge clk);
  endtask

  task automatic idle();
    launch_valid = 0; term_valid = 0;
  endtask

  task automatic look(input int s, input int sp, input bit w, input string note);
    lk_slot = 3'(s); lk_spec = 5'(sp); lk_write = w;
    cycle(note);
  endtask

  task automatic launch(input int s, input int b, input int g, input int c,
                        input int p, input bit f);
    launch_valid = 1; launch_slot = 3'(s); launch_base = 10'(b);
    launch_gbase = 10'(g); launch_cbase = 10'(c); launch_pred = 3'(p);
    launch_first = f;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int last_ls;
    for (int i = 0; i < 8; i++) m_valid[i] = 0;
    rst_n = 0; idle(); launch(0, 0, 0, 0, 0, 0); launch_valid = 0;
    term_slot = 0; lk_slot = 0; lk_spec = 12; lk_write = 0;
    @(negedge clk);
    look(0, 12, 0, "R12 lookup in reset");
    rst_n = 1;
    look(3, 20, 0, "R12 empty after reset");
    // R8: launch slot 0 as first thread, not visible in the same cycle
    launch(0, 100, 900, 500, 0, 1);
    look(0, 12, 0, "R8 same cycle still empty");
    idle();
    look(0, 12, 0, "R8 R2 local low");
    look(0, 30, 1, "R2 local write high");
    look(0, 3, 0, "R3 global read");
    look(0, 7, 1, "R3 global write refused");
    look(0, 9, 0, "R6 first shared read");
    look(0, 11, 1, "R4 shared write");
    look(0, 31, 0, "R7 zero read");
    look(0, 31, 1, "R7 zero write");
    look(0, 0, 0, "R1 spec 0");
    look(0, 8, 0, "R1 spec 8");
    // slot 1 follows slot 0, base near the top to test wrap
    launch(1, 1010, 900, 500, 0, 0);
    look(1, 20, 0, "R8 slot1 not yet");
    idle();
    look(1, 30, 0, "R2 wrap");
    look(1, 10, 0, "R5 predecessor shared read");
    look(1, 10, 1, "R4 own shared write");
    term_valid = 1; term_slot = 0;
    look(0, 12, 0, "R9 before terminate edge");
    idle();
    look(0, 12, 0, "R9 slot terminated");
    look(1, 8, 0, "R10 predecessor gone");
    look(1, 12, 0, "R10 local still fine");
    // R11 collision: launch and terminate on slot 2
    launch(2, 40, 41, 42, 1, 0);
    term_valid = 1; term_slot = 2;
    look(2, 12, 0, "R11 collide cycle");
    idle();
    look(2, 13, 0, "R11 launch wins");
    // randomized phase
    last_ls = -1;
    for (int n = 0; n < 4000; n++) begin
      int ts;
      idle();
      if ($urandom_range(0, 3) == 0)
        launch($urandom_range(0, 7), $urandom_range(0, 1023), $urandom_range(0, 1023),
               $urandom_range(0, 1023), $urandom_range(0, 7), 1'($urandom_range(0, 1)));
      if ($urandom_range(0, 4) == 0) begin
        ts = $urandom_range(0, 7);
        if (ts == last_ls) ts = (ts + 1) % 8;
        term_valid = 1; term_slot = 3'(ts);
      end
      last_ls = launch_valid ? int'(launch_slot) : -1;
      look($urandom_range(0, 7), $urandom_range(0, 31), 1'($urandom_range(0, 1)), "random");
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule